// File: doc/BRIEF.md
# Up/Down Autoreload Timer

This block is a 16-bit timer that reloads itself. Software programs a reload value and a control word through a simple register write port. Once running, the count advances on each count event. A count event is either a tick from a power-of-four prescaler on the system clock, or a chosen edge of an external clock input. The count direction comes from an external direction input when down-counting is enabled. Otherwise the timer only counts up.

When counting up, a count equal to the reload value turns into zero on the next event. When counting down, a count of zero takes the reload value on the next event. Either of these is a wrap. Each wrap sets a sticky flag that only software clears. Each wrap also toggles an extension bit, which can be read as a 17th count bit. An interrupt request follows the sticky flag, gated by an enable bit. The external clock input and the direction input each pass through a two-stage synchroniser before use.

Top module: `updown_reload_timer`

Control word layout (address 0): bit 0 run, bit 1 external source select (1 = external clock input edges), bit 2 edge select (0 = rising, 1 = falling), bit 3 down-count enable, bit 4 capture select, bit 5 interrupt enable, bits 8:6 prescale field, bit 14 extension bit, bit 15 sticky flag. Bits 13:9 read as 0. Register select codes: 0 control, 1 reload, 2 count, 3 reads 0.

## Requirements
- R1: After reset, the count, reload and control registers read 0, including the flag and extension bits, and `irq` is 0.
- R2: Counting up, an event while count equals reload loads 0 instead of incrementing. That event sets the flag (bit 15) and toggles the extension bit (bit 14).
- R3: Counting down, an event while the count is 0 loads the reload value. That event sets the flag and toggles the extension bit. Otherwise each down event decrements the count.
- R4: With down-count enable (bit 3) at 1, a synchronised direction input of 1 counts up and 0 counts down. With bit 3 at 0, the timer counts up whatever the direction input is.
- R5: With the internal source, one event occurs every 4^P system clock cycles while running, where P is the prescale field (bits 8:6). The prescaler restarts from zero each time the run bit is set again.
- R6: While the run bit (bit 0) is 0, the count does not change except through a software write.
- R7: With bit 1 at 1, each rising edge of the external clock input (bit 2 = 0) or each falling edge (bit 2 = 1) is one event. Edges of the other polarity have no effect.
- R8: The flag stays set across later events. A control write with bit 15 at 0 clears it; a control write with bit 15 at 1 leaves it unchanged.
- R9: `irq` is 1 exactly when the flag and the interrupt enable (bit 5) are both 1.
- R10: A software write to the count register in the same cycle as an event wins. The written value is loaded, and no wrap, flag set or extension toggle happens.
- R11: While capture select (bit 4) is 1, the autoreload counting is suspended and the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes (0 control, 1 reload, 2 count) |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 16 | Read data of the selected register |
| ext_clk_in | input | 1 | External count clock, asynchronous |
| dir_in | input | 1 | Count direction, asynchronous (1 up, 0 down) |
| irq | output | 1 | Interrupt request |

## Verification
Two things can land in the same cycle: a software write to the count register and a count event that would otherwise wrap the counter. The bench runs the timer at the undivided rate with a small reload value. It issues the count write on exactly the edge at which the count equals the reload value. The bench then expects the written value in the count, with the flag and extension bit still clear, and expects counting to resume from the written value on the next edge.

// File: rtl/urt_pkg.sv
package urt_pkg;

    localparam int CNT_W = 16;
    localparam int PS_W  = 3;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_RELOAD = 2'd1,
        SEL_COUNT  = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic            flag;
        logic            ext;
        logic [4:0]      rsv;
        logic [PS_W-1:0] ps;
        logic            irq_en;
        logic            cap_sel;
        logic            dcen;
        logic            fall_edge;
        logic            src_ext;
        logic            run;
    } ctrl_t;

    // Low-bit mask selecting 2*ps bits of the prescale counter
    function automatic logic [2*((1<<PS_W)-1)-1:0] presc_mask(input logic [PS_W-1:0] ps);
        logic [2*((1<<PS_W)-1)-1:0] m;
        for (int i = 0; i < 2*((1<<PS_W)-1); i++) begin
            m[i] = (i < 2*int'(ps));
        end
        return m;
    endfunction

endpackage

// File: rtl/urt_prescaler.sv
module urt_prescaler
    import urt_pkg::*;
#(
    parameter int P_W = PS_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic [P_W-1:0] ps,
    output logic           tick
);
    localparam int PRE_W = 2*((1<<P_W)-1);

    logic [PRE_W-1:0] presc_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (i < 2*int'(ps));
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) presc_q <= '0;
        else             presc_q <= presc_q + 1'b1;
    end

    assign tick = run && ((presc_q & mask) == mask);

    // R5: prescaler is back at zero after any idle cycle
    p_presc_restart_r5: assert property (@(posedge clk) disable iff (rst)
        !run |=> presc_q == '0);

endmodule

// File: rtl/urt_sync_edge.sv
module urt_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_clk_raw,
    input  logic dir_raw,
    output logic dir_sync,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] ck_sh;
    logic [STAGES-1:0] dir_sh;
    logic              ck_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_sh   <= '0;
            dir_sh  <= '0;
            ck_prev <= 1'b0;
        end else begin
            ck_sh   <= {ck_sh[STAGES-2:0], ext_clk_raw};
            dir_sh  <= {dir_sh[STAGES-2:0], dir_raw};
            ck_prev <= ck_sh[STAGES-1];
        end
    end

    assign dir_sync = dir_sh[STAGES-1];
    assign rise     = ck_sh[STAGES-1] & ~ck_prev;
    assign fall     = ~ck_sh[STAGES-1] & ck_prev;

    // R7: an edge produces a single-cycle event pulse
    p_rise_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
    p_fall_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);

endmodule

// File: rtl/urt_core.sv
module urt_core
    import urt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             tick,
    input  logic             rise,
    input  logic             fall,
    input  logic             dir_sync,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] rel_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    reg_sel_e         sel;
    logic             wr_ctrl, wr_rel, wr_cnt;
    logic             step, up, wrap;

    assign sel     = reg_sel_e'(wr_sel);
    assign wr_ctrl = wr_en && (sel == SEL_CTRL);
    assign wr_rel  = wr_en && (sel == SEL_RELOAD);
    assign wr_cnt  = wr_en && (sel == SEL_COUNT);

    assign step = ctrl_q.run && !ctrl_q.cap_sel &&
                  (ctrl_q.src_ext ? (ctrl_q.fall_edge ? fall : rise) : tick);
    assign up   = !ctrl_q.dcen || dir_sync;
    assign wrap = step && !wr_cnt && (up ? (cnt_q == rel_q) : (cnt_q == '0));

    always_comb begin
        cnt_nxt = cnt_q;
        if (wr_cnt) begin
            cnt_nxt = wr_data;
        end else if (step) begin
            if (up) cnt_nxt = wrap ? '0    : cnt_q + 1'b1;
            else    cnt_nxt = wrap ? rel_q : cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            rel_q  <= '0;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_nxt;
            if (wr_rel) rel_q <= wr_data;
            if (wr_ctrl) begin
                ctrl_q      <= ctrl_t'(wr_data);
                ctrl_q.rsv  <= '0;
                ctrl_q.flag <= (wr_data[15] & ctrl_q.flag) | wrap;
                ctrl_q.ext  <= wr_data[14] ^ wrap;
            end else if (wrap) begin
                ctrl_q.flag <= 1'b1;
                ctrl_q.ext  <= ~ctrl_q.ext;
            end
        end
    end

    assign ctrl   = ctrl_q;
    assign reload = rel_q;
    assign count  = cnt_q;

    p_up_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        step && up && !wr_cnt && cnt_q == rel_q |=> cnt_q == '0 && ctrl_q.flag);
    p_ext_toggle_r2: assert property (@(posedge clk) disable iff (rst)
        wrap && !wr_ctrl |=> ctrl_q.ext != $past(ctrl_q.ext));
    p_down_reload_r3: assert property (@(posedge clk) disable iff (rst)
        step && !up && !wr_cnt && cnt_q == '0 |=> cnt_q == $past(rel_q));
    p_down_step_r4: assert property (@(posedge clk) disable iff (rst)
        step && !up && !wr_cnt && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1);
    p_hold_stopped_r6: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.run && !wr_cnt |=> $stable(cnt_q));
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.flag && !wr_ctrl |=> ctrl_q.flag);
    p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> cnt_q == $past(wr_data));
    p_cap_hold_r11: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.cap_sel && !wr_cnt |=> $stable(cnt_q));

endmodule

// File: rtl/updown_reload_timer.sv
module updown_reload_timer
    import urt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data,
    input  logic             ext_clk_in,
    input  logic             dir_in,
    output logic             irq
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload, count;
    logic             tick, rise, fall, dir_sync;

    urt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .ext_clk_raw(ext_clk_in), .dir_raw(dir_in),
        .dir_sync(dir_sync), .rise(rise), .fall(fall)
    );

    urt_prescaler #(.P_W(PS_W)) u_presc (
        .clk(clk), .rst(rst), .run(ctrl.run), .ps(ctrl.ps), .tick(tick)
    );

    urt_core u_core (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .tick(tick), .rise(rise), .fall(fall), .dir_sync(dir_sync),
        .ctrl(ctrl), .reload(reload), .count(count)
    );

    always_comb begin
        case (reg_sel_e'(rd_sel))
            SEL_CTRL:   rd_data = ctrl;
            SEL_RELOAD: rd_data = reload;
            SEL_COUNT:  rd_data = count;
            default:    rd_data = '0;
        endcase
    end

    assign irq = ctrl.flag & ctrl.irq_en;

    // R9: a request never appears without the enable
    p_irq_gated_r9: assert property (@(posedge clk) disable iff (rst)
        !ctrl.irq_en |-> !irq);

endmodule

// File: tb/tb_updown_reload_timer.sv
`timescale 1ns/1ps
module tb_updown_reload_timer;

    localparam logic [15:0] RUN = 16'h0001, SRC = 16'h0002, FALL = 16'h0004,
                            DCEN = 16'h0008, CAP = 16'h0010, IE = 16'h0020;
    localparam logic [1:0]  A_CTRL = 2'd0, A_REL = 2'd1, A_CNT = 2'd2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic        ext_clk_in = 1'b0;
    logic        dir_in = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    updown_reload_timer dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .ext_clk_in(ext_clk_in),
        .dir_in(dir_in), .irq(irq)
    );

    function automatic logic [15:0] ps(input int p);
        return 16'(p << 6);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        rd_sel = a;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        do_reset();
        rd(A_CTRL, v); check("R1 ctrl", v, 16'h0000);
        rd(A_REL, v);  check("R1 reload", v, 16'h0000);
        rd(A_CNT, v);  check("R1 count", v, 16'h0000);
        check("R1 irq", {15'b0, irq}, 16'h0000);
    endtask

    task automatic t_up_wrap();
        logic [15:0] v;
        do_reset();
        wr(A_REL, 16'd3); wr(A_CNT, 16'd0); wr(A_CTRL, RUN | IE);
        edges(3); rd(A_CNT, v); check("R2 count at reload", v, 16'd3);
        edges(1); rd(A_CNT, v); check("R2 wrap to zero", v, 16'd0);
        rd(A_CTRL, v); check("R2 flag and ext set", v & 16'hC000, 16'hC000);
        check("R9 irq raised", {15'b0, irq}, 16'd1);
        edges(4); rd(A_CTRL, v); check("R8 flag kept, ext toggled back", v & 16'hC000, 16'h8000);
        wr(A_CTRL, RUN | IE);
        rd(A_CTRL, v); check("R8 flag cleared", v & 16'hC000, 16'h0000);
        check("R9 irq dropped", {15'b0, irq}, 16'd0);
        rd(A_CNT, v); check("R8 counting continued", v, 16'd1);
    endtask

    task automatic t_down();
        logic [15:0] v;
        dir_in = 1'b0;
        do_reset();
        wr(A_REL, 16'd5); wr(A_CNT, 16'd2); wr(A_CTRL, RUN | DCEN);
        edges(2); rd(A_CNT, v); check("R3 down to zero", v, 16'd0);
        rd(A_CTRL, v); check("R3 no flag before reload", v & 16'hC000, 16'h0000);
        edges(1); rd(A_CNT, v); check("R3 reload at zero", v, 16'd5);
        rd(A_CTRL, v); check("R3 flag and ext", v & 16'hC000, 16'hC000);
        check("R9 no irq without enable", {15'b0, irq}, 16'd0);
        edges(1); rd(A_CNT, v); check("R3 keeps counting down", v, 16'd4);
    endtask

    task automatic t_dir();
        logic [15:0] v;
        dir_in = 1'b1;
        do_reset();
        wr(A_REL, 16'd100); wr(A_CNT, 16'd10); wr(A_CTRL, RUN | DCEN);
        edges(2); rd(A_CNT, v); check("R4 dir 1 counts up", v, 16'd12);
        dir_in = 1'b0;
        do_reset();
        wr(A_CNT, 16'd10); wr(A_CTRL, RUN);
        edges(2); rd(A_CNT, v); check("R4 up only without down enable", v, 16'd12);
    endtask

    task automatic t_presc();
        logic [15:0] v;
        do_reset();
        wr(A_REL, 16'hFFFF); wr(A_CTRL, RUN | ps(1));
        edges(3); rd(A_CNT, v); check("R5 div4 before tick", v, 16'd0);
        edges(1); rd(A_CNT, v); check("R5 div4 first tick", v, 16'd1);
        edges(4); rd(A_CNT, v); check("R5 div4 second tick", v, 16'd2);
        edges(2);
        wr(A_CTRL, ps(1));
        edges(2);
        wr(A_CTRL, RUN | ps(1));
        edges(3); rd(A_CNT, v); check("R5 restart no early tick", v, 16'd2);
        edges(1); rd(A_CNT, v); check("R5 restart tick", v, 16'd3);
        do_reset();
        wr(A_REL, 16'hFFFF); wr(A_CTRL, RUN | ps(2));
        edges(15); rd(A_CNT, v); check("R5 div16 before tick", v, 16'd0);
        edges(1); rd(A_CNT, v); check("R5 div16 tick", v, 16'd1);
    endtask

    task automatic t_stop();
        logic [15:0] v;
        do_reset();
        wr(A_CNT, 16'd7); wr(A_CTRL, 16'h0000);
        edges(5); rd(A_CNT, v); check("R6 hold when stopped", v, 16'd7);
    endtask

    task automatic t_ext();
        logic [15:0] v;
        ext_clk_in = 1'b0;
        do_reset();
        wr(A_REL, 16'hFFFF); wr(A_CTRL, RUN | SRC);
        edges(2);
        ext_clk_in = 1'b1; edges(5); rd(A_CNT, v); check("R7 rising edge counts", v, 16'd1);
        ext_clk_in = 1'b0; edges(5); rd(A_CNT, v); check("R7 falling edge ignored", v, 16'd1);
        wr(A_CTRL, RUN | SRC | FALL);
        ext_clk_in = 1'b1; edges(5); rd(A_CNT, v); check("R7 rising ignored in fall mode", v, 16'd1);
        ext_clk_in = 1'b0; edges(5); rd(A_CNT, v); check("R7 falling edge counts", v, 16'd2);
    endtask

    task automatic t_prio();
        logic [15:0] v;
        do_reset();
        wr(A_REL, 16'd3); wr(A_CTRL, RUN);
        edges(3); rd(A_CNT, v); check("R10 setup at reload", v, 16'd3);
        wr(A_CNT, 16'h0040);
        rd(A_CNT, v); check("R10 write wins", v, 16'h0040);
        rd(A_CTRL, v); check("R10 no wrap side effects", v & 16'hC000, 16'h0000);
        edges(1); rd(A_CNT, v); check("R10 resumes from written value", v, 16'h0041);
    endtask

    task automatic t_cap();
        logic [15:0] v;
        do_reset();
        wr(A_CNT, 16'd9); wr(A_CTRL, RUN | CAP);
        edges(5); rd(A_CNT, v); check("R11 hold with capture select", v, 16'd9);
    endtask

    initial begin
        t_reset();
        t_up_wrap();
        t_down();
        t_dir();
        t_presc();
        t_stop();
        t_ext();
        t_prio();
        t_cap();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule